// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

The sequencer sits between the control logic of a processor core and a byte-wide memory bus. It answers two questions for the core: where execution starts after reset, and where execution goes when an interrupt of a given type is taken. Out of reset it presents a fixed start location near the top of the 1 MB space. No memory access is needed for that.

When the core raises a request carrying an 8-bit type number, the sequencer reads the four-byte pointer for that type from the table at the bottom of memory. It reads one byte at a time and waits on the memory's ready signal for each byte. It then forms the offset and the segment from the four bytes and computes the 20-bit physical target. It hands all three values to the core together with a one-cycle completion strobe. The pointer table is only read, never written.

Top module: `ivec_fetch_seq`

## Requirements
- R1: While reset is held and after it is released, with no request taken yet, the outputs show segment FFFFH, offset 0000H and physical address FFFF0H. The read strobe and the done strobe are low.
- R2: A request of type n reads byte addresses 4n, 4n+1, 4n+2 and 4n+3, in that order. Every address driven with the read strobe high lies in 00000H..003FFH.
- R3: The byte read at 4n+0 is the low half of the offset and the byte at 4n+1 is its high half. The byte at 4n+2 is the low half of the segment and the byte at 4n+3 is its high half.
- R4: During each read the address and the read strobe stay unchanged until a cycle in which ready is high. That cycle captures the byte, and exactly one byte is captured per ready cycle.
- R5: The physical output equals segment×16 + offset, truncated to 20 bits, so a sum past FFFFFH wraps to the bottom of memory.
- R6: Done is high for exactly one cycle, in the cycle right after the fourth byte is captured. In that cycle segment, offset and physical output already hold the new values, and they keep them until the next completion or reset.
- R7: A request raised while a fetch is in progress is ignored. The running fetch completes with the original type, and no further reads or completion follow.
- R8: Reset asserted during a fetch drops the read strobe at once and returns the outputs to the R1 start location. A fetch requested after reset is released works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Interrupt request, taken when the sequencer is idle |
| req_type | input | 8 | Interrupt type number carried with the request |
| mem_addr | output | 20 | Byte address of the current table read |
| mem_rd | output | 1 | Read strobe, high while a byte read is outstanding |
| mem_rdy | input | 1 | Memory ready; the byte on mem_data is captured when high |
| mem_data | input | 8 | Read data from memory |
| done | output | 1 | One-cycle strobe marking new target values |
| tgt_seg | output | 16 | Target segment |
| tgt_off | output | 16 | Target offset |
| tgt_phys | output | 20 | Target physical address |

## Verification
The bench uses table entries whose segment×16 + offset carries past the 1 MB boundary. A design that kept the carry, or shifted by the wrong amount, would show a wrong physical target. Types 0 and 255 test both ends of the table; an address scaled wrongly would leave the 000H..3FFH window, or an off-by-one read order would swap offset and segment bytes. Wait states of several cycles check that the address holds until ready, and a second request injected mid-fetch shows whether a design that is not locked while busy would restart or jump to the new type. Reset is pulled during a fetch to confirm that the read is abandoned and the start location reappears.

// File: rtl/ivec_pkg.sv
package ivec_pkg;

   // Sequencer control states
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_READ = 1'b1
   } ivec_state_t;

   // Defaults shared by the modules of the block
   localparam int unsigned IVEC_ADDR_W      = 20;
   localparam int unsigned IVEC_DATA_W      = 8;
   localparam int unsigned IVEC_SEG_W       = 16;
   localparam int unsigned IVEC_TYPE_W      = 8;
   localparam int unsigned IVEC_ENTRY_BYTES = 4;

endpackage

// File: rtl/ivec_addr_gen.sv
module ivec_addr_gen #(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned TYPE_W      = 8,
   parameter int unsigned ENTRY_BYTES = 4,
   parameter logic [ADDR_W-1:0] TABLE_BASE = '0,
   localparam int unsigned IDX_W      = $clog2(ENTRY_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TYPE_W-1:0] type_in,
   input  logic              advance,
   input  logic              busy,
   output logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              last
);

   localparam int unsigned SPAN = (1 << TYPE_W) * ENTRY_BYTES;

   if ((1 << IDX_W) != ENTRY_BYTES) begin : g_bad_entry
      $error("ENTRY_BYTES must be a power of two");
   end
   if (SPAN > (1 << ADDR_W)) begin : g_bad_span
      $error("pointer table does not fit the address space");
   end

   logic [TYPE_W-1:0] type_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q <= '0;
         idx_q  <= '0;
      end else if (start) begin
         type_q <= type_in;
         idx_q  <= '0;
      end else if (advance) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

   logic [ADDR_W-1:0] entry_start;
   assign entry_start = TABLE_BASE + (ADDR_W'(type_q) << IDX_W);
   assign addr        = entry_start + ADDR_W'(idx_q);
   assign idx         = idx_q;
   assign last        = (idx_q == IDX_W'(ENTRY_BYTES - 1));

   // R7: the latched type is frozen for the whole fetch
   a_r7_type_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> $stable(type_q));

   // R2: the byte index moves only forward by one per capture
   a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !last && !start) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/ivec_byte_asm.sv
module ivec_byte_asm #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ENTRY_BYTES = 4,
   localparam int unsigned IDX_W      = $clog2(ENTRY_BYTES),
   localparam int unsigned WORD_W     = DATA_W * ENTRY_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] data,
   output logic [WORD_W-1:0] word_next
);

   logic [WORD_W-1:0] word_q;
   logic [ENTRY_BYTES-1:0] lane_hit;

   for (genvar b = 0; b < ENTRY_BYTES; b++) begin : g_lane
      assign lane_hit[b] = capture && (idx == IDX_W'(b));
      assign word_next[b*DATA_W +: DATA_W] =
         lane_hit[b] ? data : word_q[b*DATA_W +: DATA_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q[b*DATA_W +: DATA_W] <= '0;
         end else if (lane_hit[b]) begin
            word_q[b*DATA_W +: DATA_W] <= data;
         end
      end
   end

   // R4: at most one byte lane is written per capture cycle
   a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> $countones(lane_hit) == 1);

endmodule

// File: rtl/ivec_phys_calc.sv
module ivec_phys_calc #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned SEG_W  = 16,
   localparam int unsigned SHIFT = ADDR_W - SEG_W,
   localparam int unsigned SUM_W = SEG_W + SHIFT + 1
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [SEG_W-1:0]  off,
   output logic [ADDR_W-1:0] phys
);

   if (ADDR_W <= SEG_W) begin : g_bad_shift
      $error("address must be wider than a segment");
   end

   logic [SUM_W-1:0] sum;

   assign sum  = {1'b0, seg, {SHIFT{1'b0}}} + SUM_W'(off);
   assign phys = sum[ADDR_W-1:0];

endmodule

// File: rtl/ivec_fetch_seq.sv
module ivec_fetch_seq
   import ivec_pkg::*;
#(
   parameter int unsigned ADDR_W      = IVEC_ADDR_W,
   parameter int unsigned DATA_W      = IVEC_DATA_W,
   parameter int unsigned SEG_W       = IVEC_SEG_W,
   parameter int unsigned TYPE_W      = IVEC_TYPE_W,
   parameter int unsigned ENTRY_BYTES = IVEC_ENTRY_BYTES,
   parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
   parameter logic [SEG_W-1:0] RESET_OFF = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TYPE_W-1:0] req_type,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic              mem_rdy,
   input  logic [DATA_W-1:0] mem_data,
   output logic              done,
   output logic [SEG_W-1:0]  tgt_seg,
   output logic [SEG_W-1:0]  tgt_off,
   output logic [ADDR_W-1:0] tgt_phys
);

   localparam int unsigned IDX_W     = $clog2(ENTRY_BYTES);
   localparam int unsigned WORD_W    = DATA_W * ENTRY_BYTES;
   localparam int unsigned SHIFT     = ADDR_W - SEG_W;
   localparam int unsigned TABLE_END = (1 << TYPE_W) * ENTRY_BYTES;
   localparam logic [ADDR_W-1:0] RESET_PHYS =
      ADDR_W'((ADDR_W'(RESET_SEG) << SHIFT) + ADDR_W'(RESET_OFF));

   if (WORD_W != 2 * SEG_W) begin : g_bad_word
      $error("an entry must hold exactly one offset and one segment");
   end

   ivec_state_t state_q;
   logic        accept, capture, finish, last;
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] word_next;
   logic [SEG_W-1:0]  new_off, new_seg;
   logic [ADDR_W-1:0] new_phys;

   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign capture = (state_q == ST_READ) && mem_rdy;
   assign finish  = capture && last;
   assign mem_rd  = (state_q == ST_READ);

   ivec_addr_gen #(
      .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) i_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(accept), .type_in(req_type),
      .advance(capture), .busy(mem_rd), .addr(mem_addr), .idx(idx),
      .last(last)
   );

   ivec_byte_asm #(
      .DATA_W(DATA_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) i_byte_asm (
      .clk(clk), .rst_n(rst_n), .capture(capture), .idx(idx),
      .data(mem_data), .word_next(word_next)
   );

   // Lower half of the entry is the offset, upper half the segment
   assign new_off = word_next[SEG_W-1:0];
   assign new_seg = word_next[WORD_W-1:SEG_W];

   ivec_phys_calc #(
      .ADDR_W(ADDR_W), .SEG_W(SEG_W)
   ) i_phys_calc (
      .seg(new_seg), .off(new_off), .phys(new_phys)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         done     <= 1'b0;
         tgt_seg  <= RESET_SEG;
         tgt_off  <= RESET_OFF;
         tgt_phys <= RESET_PHYS;
      end else begin
         done <= finish;
         case (state_q)
            ST_IDLE: if (accept) state_q <= ST_READ;
            ST_READ: if (finish) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
         if (finish) begin
            tgt_seg  <= new_seg;
            tgt_off  <= new_off;
            tgt_phys <= new_phys;
         end
      end
   end

   // R2: reads never leave the pointer table
   a_r2_table_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (mem_addr < ADDR_W'(TABLE_END)));

   // R4: an unanswered read holds its address and strobe
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

   // R6: done is a single-cycle strobe
   a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: outputs hold between completions
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(tgt_seg) && $stable(tgt_off) && $stable(tgt_phys)));

   // R5: the low nibble of the target comes straight from the offset
   a_r5_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tgt_phys[SHIFT-1:0] == tgt_off[SHIFT-1:0]));

endmodule

// File: tb/test_ivec_fetch_seq.sv
module test_ivec_fetch_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_type = '0;
   logic [19:0] mem_addr;
   logic        mem_rd;
   logic        mem_rdy;
   logic [7:0]  mem_data;
   logic        done;
   logic [15:0] tgt_seg, tgt_off;
   logic [19:0] tgt_phys;

   always #5 clk = ~clk;

   ivec_fetch_seq i_ivec_fetch_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdy(mem_rdy),
      .mem_data(mem_data), .done(done), .tgt_seg(tgt_seg),
      .tgt_off(tgt_off), .tgt_phys(tgt_phys)
   );

   // Memory model: 1 KB table with programmable wait states
   logic [7:0] mem [0:1023];
   int wait_cfg = 0;
   int wait_cnt = 0;

   assign mem_data = mem[mem_addr[9:0]];
   assign mem_rdy  = mem_rd && (wait_cnt >= wait_cfg);

   always @(posedge clk) begin
      if (!mem_rd || mem_rdy) wait_cnt <= 0;
      else                    wait_cnt <= wait_cnt + 1;
   end

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   task automatic set_entry(int n, logic [15:0] seg, logic [15:0] off);
      mem[4*n+0] = off[7:0];
      mem[4*n+1] = off[15:8];
      mem[4*n+2] = seg[7:0];
      mem[4*n+3] = seg[15:8];
   endtask

   // Full fetch of type n; inj >= 0 injects a second request mid-fetch
   task automatic do_fetch(string tag, int n, int waits, int inj);
      logic [15:0] eo, es;
      logic [20:0] sum;
      int reads = 0;
      int it = 0;
      bit held_checked = 0;
      logic [19:0] hold_addr;
      eo = {mem[4*n+1], mem[4*n+0]};
      es = {mem[4*n+3], mem[4*n+2]};
      sum = {1'b0, es, 4'h0} + 21'(eo);
      wait_cfg = waits;
      @(negedge clk);
      req_valid = 1'b1;
      req_type  = 8'(n);
      @(negedge clk);
      req_valid = 1'b0;
      while (reads < 4 && it < 200) begin
         it++;
         if (inj >= 0 && it == 3) begin
            req_valid = 1'b1;
            req_type  = 8'(inj);
         end else begin
            req_valid = 1'b0;
         end
         if (mem_rd && mem_rdy) begin
            chk({tag, " R2 address"}, 32'(mem_addr), 32'(4*n + reads));
            reads++;
            if (reads < 4) @(negedge clk);
         end else if (mem_rd) begin
            hold_addr = mem_addr;
            @(negedge clk);
            if (!held_checked) begin
               held_checked = 1;
               chk({tag, " R4 strobe held"}, 32'(mem_rd), 32'd1);
               chk({tag, " R4 address held"}, 32'(mem_addr), 32'(hold_addr));
            end
         end else begin
            chk({tag, " R4 strobe during fetch"}, 32'(mem_rd), 32'd1);
            @(negedge clk);
         end
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk({tag, " R6 done after last byte"}, 32'(done), 32'd1);
      chk({tag, " R3 offset"}, 32'(tgt_off), 32'(eo));
      chk({tag, " R3 segment"}, 32'(tgt_seg), 32'(es));
      chk({tag, " R5 physical"}, 32'(tgt_phys), 32'(sum[19:0]));
      @(negedge clk);
      chk({tag, " R6 done single cycle"}, 32'(done), 32'd0);
      chk({tag, " R6 outputs held"}, 32'(tgt_off), 32'(eo));
      if (inj >= 0) begin
         // R7: no further reads or completion from the ignored request
         for (int k = 0; k < 12; k++) begin
            if (mem_rd || done) begin
               chk({tag, " R7 ignored request started work"}, 32'(mem_rd | done), 32'd0);
               break;
            end
            @(negedge clk);
         end
         chk({tag, " R7 idle after fetch"}, 32'(mem_rd), 32'd0);
         chk({tag, " R7 result of first type"}, 32'(tgt_seg), 32'(es));
      end
   endtask

   task automatic t_reset_state();
      chk("R1 segment", 32'(tgt_seg), 32'h0000FFFF);
      chk("R1 offset", 32'(tgt_off), 32'h0);
      chk("R1 physical", 32'(tgt_phys), 32'h000FFFF0);
      chk("R1 no read", 32'(mem_rd), 32'd0);
      chk("R1 no done", 32'(done), 32'd0);
   endtask

   task automatic t_reset_midfetch();
      int reads = 0;
      wait_cfg = 1;
      @(negedge clk);
      req_valid = 1'b1;
      req_type  = 8'd40;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 50 && reads < 2; k++) begin
         if (mem_rd && mem_rdy) reads++;
         @(negedge clk);
      end
      chk("R8 fetch in progress", 32'(mem_rd), 32'd1);
      rst_n = 1'b0;
      #1;
      chk("R8 strobe dropped", 32'(mem_rd), 32'd0);
      @(negedge clk);
      chk("R8 segment", 32'(tgt_seg), 32'h0000FFFF);
      chk("R8 offset", 32'(tgt_off), 32'h0);
      chk("R8 physical", 32'(tgt_phys), 32'h000FFFF0);
      chk("R8 no done", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 idle after release", 32'(mem_rd), 32'd0);
      do_fetch("R8 after reset", 41, 0, -1);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 73 + 29) ^ (i >> 3));
      set_entry(5, 16'hF000, 16'hFFFF);   // sums exactly to FFFFFH
      set_entry(6, 16'hFFFF, 16'h0020);   // carries past 1 MB, wraps to 00010H
      set_entry(7, 16'hFFFF, 16'hFFFF);   // largest wrap
      set_entry(255, 16'h1234, 16'hABCD);
      set_entry(0, 16'h0070, 16'h0108);
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_state();
      do_fetch("type 21h", 8'h21, 0, -1);
      do_fetch("type 0", 0, 2, -1);
      do_fetch("type 255", 255, 3, -1);
      do_fetch("R5 top", 5, 0, -1);
      do_fetch("R5 wrap", 6, 1, -1);
      do_fetch("R5 max wrap", 7, 0, -1);
      do_fetch("R7 busy", 10, 4, 20);
      do_fetch("R7 busy nowait", 12, 0, 99);
      t_reset_midfetch();
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

endmodule